// File: doc/BRIEF.md
# Scaler Tile Parameter Calculator

This block works out the set-up values a one-axis image scaler needs before it begins a frame. It takes a frame input length, a frame output length and a flag that selects whether the axis is processed as one tile or split into a left and a right tile. From these it derives a fixed-point step with a 15-bit fraction (one input pixel is 32768 phase units), plus, for each tile, a start offset split into an integer part and a subpixel part, and the tile's input and output lengths.

The step is rounded upward so the last output sample never lands past the last input pixel. The start phase is pulled back by half of the rounding excess, which centres the sampling grid on the frame. In the split mode each tile reads 4 pixels beyond the frame's midpoint as filter margin. The right tile's start is rebased to its own first input pixel, and it is moved to an even integer offset when needed. All divisions run on a restoring divider that produces one quotient bit per cycle. The one multiplication runs as a shift-and-add that uses one multiplier bit per cycle.

A request is a one-cycle pulse on `start_i`. Results appear together with a one-cycle `done_o` and stay on the outputs until the next accepted request completes.

Top module: `tile_param_calc`

## Requirements
- R1: With A = 32768*(in_len-1) and B = out_len-1, `step_o` equals the ceiling of A/B, computed as floor((A+B-1)/B).
- R2: With the residual e = (step*B - A)/2 (truncating) and phase p = 32768 - e, `l_int_o` = p/32768 and `l_sub_o` = p mod 32768.
- R3: In single-tile mode (`dual_i`=0), `l_in_len_o` = in_len and `tile_out_len_o` = out_len. All three right-tile outputs are 0.
- R4: In dual-tile mode, `l_in_len_o` = in_len/2 + 4 and `tile_out_len_o` = out_len/2, both quotients truncating.
- R5: In dual-tile mode, with h = 1 when e is nonzero and 0 otherwise, the right phase is q = (p + (out_len/2)*step - (in_len/2 - 4 - h + 1)*32768 + 32768) mod 2^32. `r_sub_o` = q mod 32768, and the pre-adjustment integer offset is q/32768, kept to 17 bits.
- R6: In dual-tile mode, `r_in_len_o` = in_len/2 + 4 + h, plus one when the adjustment of R7 applies.
- R7: When the pre-adjustment right integer offset is odd, `r_int_o` is that value plus one. Otherwise `r_int_o` is that value unchanged. Either way, `r_int_o` is always even.
- R8: A start with out_len below 2 or in_len of 0 gives `done_o` and `err_o` high in the cycle after the start edge and leaves every result output unchanged. `err_o` stays high until the next accepted request, and it clears on that request's start edge.
- R9: For an accepted request, `done_o` rises exactly 49 clock edges after the start edge (32 divider cycles, 16 multiplier cycles and one finishing cycle) and lasts one cycle. Result outputs change only in a cycle where `done_o` is high.
- R10: A start pulse that arrives while a request is in progress is ignored. The running request completes with its own inputs.
- R11: After reset, `done_o` and `err_o` are 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; latches the inputs when idle |
| dual_i | input | 1 | 1 = left and right tile, 0 = single tile |
| in_len_i | input | 16 | Frame input length |
| out_len_i | input | 16 | Frame output length |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request had invalid lengths |
| step_o | output | 32 | Step, 15 fraction bits |
| l_int_o | output | 17 | Left tile integer offset |
| l_sub_o | output | 15 | Left tile subpixel offset |
| l_in_len_o | output | 16 | Left tile input length |
| tile_out_len_o | output | 16 | Output length per tile |
| r_int_o | output | 17 | Right tile integer offset |
| r_sub_o | output | 15 | Right tile subpixel offset |
| r_in_len_o | output | 16 | Right tile input length |

## Verification
A wrong quotient bit or remainder in the divider shows up first in `step_o` and in the left offsets. It also spreads into the right offset through the residual, and all of this appears at the next `done_o`, 49 cycles after the start. A slip in the sequencer counts moves the `done_o` edge, and the bench's cycle-exact model reports that in the very cycle it happens. A bad multiplier bit disturbs only the right-tile offset and the evenness rule, so the split-mode runs cover a wide spread of length pairs. Those runs include pairs that force the odd-to-even adjustment.

// File: rtl/tile_param_calc.sv
module tile_param_calc #(
  parameter int LEN_W  = 16,
  parameter int FRAC_W = 15,
  parameter int LOSS   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          dual_i,
  input  logic [LEN_W-1:0]              in_len_i,
  input  logic [LEN_W-1:0]              out_len_i,
  output logic                          done_o,
  output logic                          err_o,
  output logic [LEN_W+FRAC_W:0]         step_o,
  output logic [LEN_W:0]                l_int_o,
  output logic [FRAC_W-1:0]             l_sub_o,
  output logic [LEN_W-1:0]              l_in_len_o,
  output logic [LEN_W-1:0]              tile_out_len_o,
  output logic [LEN_W:0]                r_int_o,
  output logic [FRAC_W-1:0]             r_sub_o,
  output logic [LEN_W-1:0]              r_in_len_o
);
  localparam int NUM_W = LEN_W + FRAC_W + 1;
  localparam int INT_W = NUM_W - FRAC_W;
  localparam int CNT_W = $clog2(NUM_W);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_MUL, S_FIN} state_t;
  state_t state;

  logic [LEN_W-1:0] in_q, out_q, rem, mpl;
  logic             dual_q;
  logic [NUM_W-1:0] quo, acc;
  logic [CNT_W-1:0] cnt;
  logic             idle;

  assign idle = (state == S_IDLE);

  wire              bad_in   = (out_len_i < LEN_W'(2)) || (in_len_i == '0);
  wire [NUM_W-1:0]  dividend = (NUM_W'(in_len_i - LEN_W'(1)) << FRAC_W)
                               + NUM_W'(out_len_i) - NUM_W'(2);

  wire [LEN_W-1:0]  dvs   = out_q - LEN_W'(1);
  wire [LEN_W:0]    trial = {rem, quo[NUM_W-1]};
  wire              ge    = trial >= {1'b0, dvs};
  wire [LEN_W:0]    diff  = trial - {1'b0, dvs};

  wire [LEN_W-1:0]  gap     = dvs - LEN_W'(1) - rem;
  wire [LEN_W-1:0]  off0    = gap >> 1;
  wire              has_off = |off0;
  wire [NUM_W-1:0]  phase   = NUM_W'(1 << FRAC_W) - NUM_W'(off0);
  wire [LEN_W-1:0]  half_in = in_q >> 1;
  wire [NUM_W-1:0]  base    = NUM_W'(half_in) - NUM_W'(LOSS) - NUM_W'(has_off);
  wire [NUM_W-1:0]  off1    = phase + acc - (base << FRAC_W);
  wire [INT_W-1:0]  r_raw   = off1[NUM_W-1:FRAC_W];
  wire              odd     = r_raw[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      in_q           <= '0;
      out_q          <= '0;
      dual_q         <= 1'b0;
      rem            <= '0;
      mpl            <= '0;
      quo            <= '0;
      acc            <= '0;
      cnt            <= '0;
      done_o         <= 1'b0;
      err_o          <= 1'b0;
      step_o         <= '0;
      l_int_o        <= '0;
      l_sub_o        <= '0;
      l_in_len_o     <= '0;
      tile_out_len_o <= '0;
      r_int_o        <= '0;
      r_sub_o        <= '0;
      r_in_len_o     <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          in_q   <= in_len_i;
          out_q  <= out_len_i;
          dual_q <= dual_i;
          if (bad_in) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            err_o <= 1'b0;
            quo   <= dividend;
            rem   <= '0;
            cnt   <= '0;
            state <= S_DIV;
          end
        end
        S_DIV: begin
          quo <= {quo[NUM_W-2:0], ge};
          rem <= ge ? diff[LEN_W-1:0] : trial[LEN_W-1:0];
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(NUM_W - 1)) begin
            cnt   <= '0;
            acc   <= '0;
            mpl   <= out_q >> 1;
            state <= S_MUL;
          end
        end
        S_MUL: begin
          acc <= {acc[NUM_W-2:0], 1'b0} + (mpl[LEN_W-1] ? quo : '0);
          mpl <= mpl << 1;
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(LEN_W - 1)) state <= S_FIN;
        end
        default: begin
          step_o  <= quo;
          l_int_o <= phase[NUM_W-1:FRAC_W];
          l_sub_o <= phase[FRAC_W-1:0];
          if (dual_q) begin
            l_in_len_o     <= half_in + LEN_W'(LOSS);
            tile_out_len_o <= out_q >> 1;
            r_int_o        <= r_raw + INT_W'(odd);
            r_sub_o        <= off1[FRAC_W-1:0];
            r_in_len_o     <= half_in + LEN_W'(LOSS) + LEN_W'(has_off) + LEN_W'(odd);
          end else begin
            l_in_len_o     <= in_q;
            tile_out_len_o <= out_q;
            r_int_o        <= '0;
            r_sub_o        <= '0;
            r_in_len_o     <= '0;
          end
          done_o <= 1'b1;
          state  <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module tile_param_calc_chk #(
  parameter int LEN_W  = 16,
  parameter int FRAC_W = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  idle,
  input logic                  dual_q,
  input logic [LEN_W-1:0]      in_q,
  input logic [LEN_W-1:0]      out_q,
  input logic                  done_o,
  input logic                  err_o,
  input logic [LEN_W+FRAC_W:0] step_o,
  input logic [LEN_W:0]        r_int_o,
  input logic [LEN_W-1:0]      l_in_len_o,
  input logic [LEN_W-1:0]      r_in_len_o
);
  localparam int LAT = 2 * LEN_W + FRAC_W + 2;
  int lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= 0;
    else if (idle && start_i) lat_cnt <= 0;
    else if (lat_cnt < LAT + 2) lat_cnt <= lat_cnt + 1;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> lat_cnt == LAT);
  // R9
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(step_o));
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> err_o == ((out_q < LEN_W'(2)) || (in_q == '0)));
  // R7
  even_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !r_int_o[0]);
  // R3
  single_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && !dual_q) |-> (r_in_len_o == '0 && l_in_len_o == in_q));
endmodule

bind tile_param_calc tile_param_calc_chk #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .idle(idle), .dual_q(dual_q),
  .in_q(in_q), .out_q(out_q), .done_o(done_o), .err_o(err_o), .step_o(step_o),
  .r_int_o(r_int_o), .l_in_len_o(l_in_len_o), .r_in_len_o(r_in_len_o)
);

// File: tb/test_tile_param_calc.sv
`timescale 1ns/1ps
module test_tile_param_calc;
  localparam int LAT = 49;

  typedef struct packed {
    logic [31:0] step;
    logic [16:0] lint;
    logic [14:0] lsub;
    logic [15:0] lin;
    logic [15:0] tout;
    logic [16:0] rint;
    logic [14:0] rsub;
    logic [15:0] rin;
    logic        forced;
  } res_t;

  logic clk = 0, rst_n = 0, start = 0, dual = 0;
  logic [15:0] in_len = 0, out_len = 0;
  logic done, err;
  logic [31:0] step;
  logic [16:0] lint, rint;
  logic [14:0] lsub, rsub;
  logic [15:0] lin, tout, rin;

  int checks = 0, fails = 0, n_forced = 0;
  bit timed_out = 0;

  always #5 clk = ~clk;

  tile_param_calc i_tile_param_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dual_i(dual),
    .in_len_i(in_len), .out_len_i(out_len), .done_o(done), .err_o(err),
    .step_o(step), .l_int_o(lint), .l_sub_o(lsub), .l_in_len_o(lin),
    .tile_out_len_o(tout), .r_int_o(rint), .r_sub_o(rsub), .r_in_len_o(rin)
  );

  function automatic res_t calc(input longint in_l, input longint out_l, input bit dl);
    res_t r;
    longint a, b, st, e, p, h, q, ri, rl;
    a  = 32768 * (in_l - 1);
    b  = out_l - 1;
    st = (a + b - 1) / b;
    e  = (st * b - a) / 2;
    p  = 32768 - e;
    r = '0;
    r.step = st[31:0];
    r.lint = p[16:0] >> 15;
    r.lsub = p[14:0];
    if (!dl) begin
      r.lin  = in_l[15:0];
      r.tout = out_l[15:0];
    end else begin
      h  = (e != 0) ? 1 : 0;
      r.lin  = 16'(in_l / 2 + 4);
      r.tout = 16'(out_l / 2);
      q  = (p + (out_l / 2) * st - (in_l / 2 - 4 - h + 1) * 32768 + 32768) & 64'hFFFF_FFFF;
      ri = q >> 15;
      rl = in_l / 2 + 4 + h;
      r.rsub = q[14:0];
      if (ri % 2 == 1) begin
        ri = ri + 1;
        rl = rl + 1;
        r.forced = 1;
      end
      r.rint = ri[16:0];
      r.rin  = rl[15:0];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // cycle-level reference
  int   m_cnt = 0;
  bit   m_done = 0, m_err = 0, m_dual = 0, p_dual = 0;
  res_t m_res = '0, m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_err = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          m_res  = m_pend;
          m_dual = p_dual;
        end
      end else if (start) begin
        if (out_len < 2 || in_len == 0) begin
          m_done = 1;
          m_err  = 1;
          m_dual = dual;
        end else begin
          m_err  = 0;
          m_pend = calc(in_len, out_len, dual);
          p_dual = dual;
          m_cnt  = LAT;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(done == m_done, "R9", done, m_done);
    chk(err == m_err, "R8", err, m_err);
    chk(step == m_res.step, "R1", step, m_res.step);
    chk({lint, lsub} == {m_res.lint, m_res.lsub}, "R2", {lint, lsub}, {m_res.lint, m_res.lsub});
    chk({lin, tout} == {m_res.lin, m_res.tout}, "R4", {lin, tout}, {m_res.lin, m_res.tout});
    chk({rint, rsub} == {m_res.rint, m_res.rsub}, "R5", {rint, rsub}, {m_res.rint, m_res.rsub});
    chk(rin == m_res.rin, "R6", rin, m_res.rin);
    if (m_done && !m_err && m_dual) begin
      chk(rint[0] == 1'b0, "R7", rint, m_res.rint);
      if (m_res.forced) n_forced++;
    end
    if (m_done && !m_err && !m_dual)
      chk(rin == 0 && rint == 0 && rsub == 0, "R3", {rint, rsub, rin}, 0);
  end

  task automatic pulse(input int i_l, input int o_l, input bit d);
    @(negedge clk);
    in_len = 16'(i_l); out_len = 16'(o_l); dual = d; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < LAT + 5; k++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic run(input int i_l, input int o_l, input bit d);
    pulse(i_l, o_l, d);
    wait_done();
  endtask

  initial begin
    #(200000 * 10);
    timed_out = 1;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    res_t ref_a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk(done == 0 && err == 0 && step == 0 && lint == 0 && rin == 0 && lin == 0,
        "R11", {done, err, step}, 0);

    run(640, 1280, 0);
    run(640, 1280, 1);
    run(100, 100, 1);
    run(1, 2, 0);
    run(2, 2, 1);
    run(1, 9, 1);
    run(65535, 65535, 1);
    run(1080, 2400, 1);
    run(720, 1080, 1);
    run(3000, 17, 1);
    // R8: invalid lengths
    run(100, 1, 1);
    run(100, 0, 0);
    run(0, 200, 1);
    run(300, 900, 0);
    // R10: start while busy is ignored
    ref_a = calc(500, 1333, 1);
    pulse(500, 1333, 1);
    repeat (10) @(negedge clk);
    pulse(7, 5000, 0);
    wait_done();
    chk(step == ref_a.step && rint == ref_a.rint, "R10", step, ref_a.step);

    for (int n = 0; n < 60 && !timed_out; n++) begin
      int i_l, o_l;
      seed = seed * 1103515245 + 12345;
      i_l = 2 + int'((seed >> 8) % 3000);
      seed = seed * 1103515245 + 12345;
      o_l = 2 + int'((seed >> 8) % 6000);
      run(i_l, o_l, n % 3 != 0);
    end
    // R7: the odd-to-even adjustment occurred at least once
    chk(n_forced > 0, "R7", n_forced, 1);

    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog act=1 exp=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (timed_out);
    checks++; fails++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule